// File: doc/BRIEF.md
# Sector Write-Protection Register Unit

This unit holds the write-protection setting of a 4 KB nonvolatile array and judges every modifying request against it. While reset is held, the register copies a configuration byte that arrives on an input port. After reset, software may write the register, but the two enable bits can only move toward more protection. The window-size field locks as soon as range protection is switched on.

Each request has a kind (program word, erase sector, modify sector or erase whole array) and a 12-bit byte offset. A request is checked against the register value held at the moment it is presented. A refused request produces a single-cycle `violation` pulse on the next clock. The array itself and the storage of the configuration byte lie outside the unit. The protected window starts at the top of the array and grows downward in 64-byte steps.

Top module: `sector_lock_unit`

## Requirements
- R1: At every rising clock edge with `rst_n` low, the whole register is loaded from `boot_cfg`, and `rd_data` shows that value from then on until the next write.
- R2: The register layout is bit 7 = global open, bits 6:4 = reserved, bit 3 = range-guard disable, bits 2:0 = window size code. `rd_data` always shows the register. The reserved bits keep their loaded value whatever is written to them.
- R3: A write takes effect on the next clock. A write with 0 in bit 7 clears global open, and a write with 0 in bit 3 clears range-guard disable. Writing 1 to either bit leaves it unchanged, so once a bit is 0 it stays 0 until reset.
- R4: The size code takes `wr_data[2:0]` only when range-guard disable was 1 before the write. This holds even when the same write clears that bit. Otherwise the size code is unchanged.
- R5: While global open is 0, every request of every kind at any offset is refused.
- R6: With global open 1 and range-guard disable 0, a program, sector erase or modify request is refused exactly when its offset, with bits 1:0 forced to 0, is at least 4096 − 64×(code+1). Code 0 therefore protects 0xFC0..0xFFF, and code 7 protects 0xE00..0xFFF.
- R7: With global open 1 and range-guard disable 1, no program, sector erase or modify request is refused.
- R8: A whole-array erase is refused unless global open and range-guard disable are both 1. Its offset plays no part in the decision.
- R9: `violation` is high for exactly the one cycle after a refused request is presented with `cmd_valid` high, and it is low in all other cycles. The decision uses the register value from before any write made in the same cycle.
- R10: `cmd_kind` encodes the request kind as 2'b00 program, 2'b01 sector erase, 2'b10 sector modify and 2'b11 whole-array erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the register from `boot_cfg` |
| boot_cfg | input | 8 | Configuration byte loaded during reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| cmd_valid | input | 1 | A request is presented this cycle |
| cmd_kind | input | 2 | Request kind (see R10) |
| cmd_offset | input | 12 | Byte offset targeted by the request |
| rd_data | output | 8 | Current register value |
| violation | output | 1 | One-cycle pulse for a refused request |

## Verification
The embedded properties watch several rules on every cycle:
- the one-way behaviour of both enable bits,
- the frozen size code once the range guard is on,
- the fixed reserved field,
- refusal of all requests while the array is closed,
- the gating of whole-array erase,
- the absence of pulses without a request.

Other behaviour needs the bench's scenarios:
- the exact window boundary for different size codes, including the sector alignment of offsets just below and above it;
- the ordering of a write and a request in the same cycle;
- reloads from different configuration bytes.

// File: rtl/sector_lock_pkg.sv
package sector_lock_pkg;

    typedef enum logic [1:0] {
        REQ_PROGRAM = 2'b00,
        REQ_ERASE   = 2'b01,
        REQ_MODIFY  = 2'b10,
        REQ_MASS    = 2'b11
    } req_kind_e;

    // Field order is fixed: software decodes this byte.
    typedef struct packed {
        logic       open;
        logic [2:0] rsv;
        logic       guard_off;
        logic [2:0] span;
    } lock_cfg_t;

endpackage

// File: rtl/sector_lock_reg.sv
module sector_lock_reg
    import sector_lock_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic [7:0] boot_cfg,
    input  logic      wr_en,
    input  logic [7:0] wr_data,
    output lock_cfg_t cfg_q
);

    typedef struct packed {
        lock_cfg_t cfg;
    } reg_state_t;

    reg_state_t st_d, st_q;
    lock_cfg_t  wr_view;

    always_comb begin
        wr_view = lock_cfg_t'(wr_data);
        st_d    = st_q;
        if (wr_en) begin
            // enable bits may only drop toward the protected state
            st_d.cfg.open      = st_q.cfg.open & wr_view.open;
            st_d.cfg.guard_off = st_q.cfg.guard_off & wr_view.guard_off;
            // size code follows the guard state from before this write
            if (st_q.cfg.guard_off) begin
                st_d.cfg.span = wr_view.span;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg <= lock_cfg_t'(boot_cfg);
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q = st_q.cfg;

    // R3: a cleared open bit never returns to 1
    p_open_oneway_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.cfg.open |=> !st_q.cfg.open);

    // R3: a cleared guard-disable bit never returns to 1
    p_guard_oneway_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.cfg.guard_off |=> !st_q.cfg.guard_off);

    // R4: size code frozen once the range guard is active
    p_span_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.cfg.guard_off |=> $stable(st_q.cfg.span));

    // R2: reserved field only changes through reset
    p_rsv_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(st_q.cfg.rsv));

endmodule

// File: rtl/sector_window_check.sv
module sector_window_check
    import sector_lock_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int STEP_BYTES = 64,
    parameter int ALIGN_BITS = 2
) (
    input  lock_cfg_t         cfg,
    input  req_kind_e         kind,
    input  logic [ADDR_W-1:0] offset,
    output logic              refuse
);

    localparam int              EXT_W       = ADDR_W + 1;
    localparam int              ARRAY_BYTES = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LOW_MASK  = ADDR_W'((1 << ALIGN_BITS) - 1);

    logic [EXT_W-1:0] span_plus;
    logic [EXT_W-1:0] floor_w;
    logic [EXT_W-1:0] sector_w;
    logic             in_window;

    always_comb begin
        span_plus = EXT_W'(cfg.span) + EXT_W'(1);
        floor_w   = EXT_W'(ARRAY_BYTES) - EXT_W'(STEP_BYTES) * span_plus;
        sector_w  = {1'b0, offset & ~LOW_MASK};
        in_window = (sector_w >= floor_w);

        if (kind == REQ_MASS) begin
            refuse = !(cfg.open && cfg.guard_off);
        end else begin
            refuse = !cfg.open || (!cfg.guard_off && in_window);
        end
    end

endmodule

// File: rtl/sector_lock_unit.sv
module sector_lock_unit
    import sector_lock_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int STEP_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        boot_cfg,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic [ADDR_W-1:0] cmd_offset,
    output logic [7:0]        rd_data,
    output logic              violation
);

    typedef struct packed {
        logic viol;
    } top_state_t;

    lock_cfg_t  cfg_q;
    logic       refuse;
    top_state_t st_d, st_q;

    sector_lock_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_cfg (boot_cfg),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cfg_q    (cfg_q)
    );

    sector_window_check #(
        .ADDR_W     (ADDR_W),
        .STEP_BYTES (STEP_BYTES),
        .ALIGN_BITS (2)
    ) u_chk (
        .cfg    (cfg_q),
        .kind   (req_kind_e'(cmd_kind)),
        .offset (cmd_offset),
        .refuse (refuse)
    );

    always_comb begin
        st_d      = st_q;
        st_d.viol = cmd_valid && refuse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data   = cfg_q;
    assign violation = st_q.viol;

    // R5: closed array refuses everything
    p_closed_refuses_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !rd_data[7]) |=> violation);

    // R8: whole-array erase needs both enables
    p_mass_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'b11 && !(rd_data[7] && rd_data[3])) |=> violation);

    // R7: fully open array accepts local requests
    p_open_accepts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind != 2'b11 && rd_data[7] && rd_data[3]) |=> !violation);

    // R9: no pulse without a request
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !violation);

endmodule

// File: tb/sim_sector_lock_unit.sv
`timescale 1ns/1ps
module sim_sector_lock_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  boot_cfg = 8'hFF;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = 2'b00;
    logic [11:0] cmd_offset = 12'h000;
    logic [7:0]  rd_data;
    logic        violation;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference state
    int  m_reg  = 0;
    bit  m_viol = 0;

    always #2 clk = ~clk;

    sector_lock_unit u0 (
        .clk(clk), .rst_n(rst_n), .boot_cfg(boot_cfg),
        .wr_en(wr_en), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_offset(cmd_offset),
        .rd_data(rd_data), .violation(violation)
    );

    function automatic bit model_refuse(int r, int kind, int off);
        bit op, gd;
        int bottom, sect;
        op     = ((r / 128) % 2) == 1;
        gd     = ((r / 8) % 2) == 1;
        bottom = 4096 - 64 * ((r % 8) + 1);
        sect   = (off / 4) * 4;
        if (kind == 3) return !(op && gd);
        if (!op) return 1;
        if (gd) return 0;
        return sect >= bottom;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg  = boot_cfg;
            m_viol = 0;
        end else begin
            int nr;
            m_viol = cmd_valid && model_refuse(m_reg, cmd_kind, cmd_offset);
            if (wr_en) begin
                nr = m_reg;
                if (!wr_data[7] && (nr & 128) != 0) nr = nr - 128;
                if (!wr_data[3] && (nr & 8) != 0) nr = nr - 8;
                if ((m_reg & 8) != 0) nr = (nr / 8) * 8 + (wr_data % 8);
                m_reg = nr;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 readback vs model", rd_data, m_reg);
            chk("R9 violation vs model", violation, m_viol);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic do_reset(logic [7:0] cfg);
        rst_n = 1'b0;
        boot_cfg = cfg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        boot_cfg = ~cfg;
    endtask

    task automatic do_write(logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_cmd(logic [1:0] k, logic [11:0] off, bit exp, string tag);
        cmd_valid = 1'b1;
        cmd_kind = k;
        cmd_offset = off;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(tag, violation, exp);
    endtask

    initial begin
        @(negedge clk);
        do_reset(8'hFF);
        chk("R1 reset load FF", rd_data, 8'hFF);
        do_cmd(2'b00, 12'hFFF, 0, "R7 open program top");
        do_cmd(2'b11, 12'h000, 0, "R8 mass allowed");
        do_cmd(2'b01, 12'h800, 0, "R7 open erase");

        do_write(8'hF7);
        chk("R3 guard cleared, size 7 taken", rd_data, 8'hF7);
        do_write(8'hFF);
        chk("R3 guard stays cleared", rd_data, 8'hF7);
        do_write(8'hF0);
        chk("R4 size frozen", rd_data, 8'hF7);
        do_cmd(2'b00, 12'hDFF, 0, "R6 below window code7");
        do_cmd(2'b00, 12'hE00, 1, "R6 window bottom code7");
        do_cmd(2'b01, 12'hE03, 1, "R10 erase kind in window");
        do_cmd(2'b10, 12'hFFF, 1, "R6 modify top");
        do_cmd(2'b11, 12'h000, 1, "R8 mass refused with guard");

        do_reset(8'h8A);
        chk("R1 reset load 8A", rd_data, 8'h8A);
        do_write(8'h80);
        chk("R4 size written as guard clears", rd_data, 8'h80);
        do_cmd(2'b00, 12'hFBF, 0, "R6 aligned below window code0");
        do_cmd(2'b00, 12'hFC1, 1, "R6 inside window code0");
        do_cmd(2'b10, 12'hFC0, 1, "R10 modify kind at bottom");
        do_write(8'h08);
        chk("R3 open cleared", rd_data, 8'h00);
        do_write(8'h88);
        chk("R3 open stays cleared", rd_data, 8'h00);
        do_cmd(2'b00, 12'h000, 1, "R5 closed program low");
        do_cmd(2'b11, 12'h123, 1, "R8 mass refused closed");

        do_reset(8'hFF);
        wr_en = 1'b1; wr_data = 8'h77;
        cmd_valid = 1'b1; cmd_kind = 2'b00; cmd_offset = 12'hFFF;
        @(negedge clk);
        wr_en = 1'b0; cmd_valid = 1'b0;
        chk("R9 decision uses pre-write value", violation, 0);
        chk("R2 reserved kept, fields written", rd_data, 8'h77);
        do_cmd(2'b00, 12'h000, 1, "R5 closed after write");
        @(negedge clk);
        chk("R9 pulse lasts one cycle", violation, 0);

        do_reset(8'h8F);
        do_write(8'hFF);
        chk("R2 reserved bits read-only", rd_data, 8'h8F);
        do_reset(8'h0F);
        chk("R1 reset load 0F", rd_data, 8'h0F);
        do_cmd(2'b11, 12'h000, 1, "R8 mass refused open=0");
        do_cmd(2'b01, 12'h004, 1, "R5 closed erase");

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule